// File: doc/BRIEF.md
# Multi-Signal Trigger Condition Evaluator

This block decides on every clock cycle whether a capture trigger should fire. It watches a set of multi-bit probe buses and a set of single-bit probe flags. Each probe forms one term of the trigger condition, and each term can be switched on or off at run time. A bus term is true when the bus exactly equals its programmed match value. A flag term is true when the flag meets its selected level or edge condition.

All enabled terms are merged by one global operator, AND or OR, chosen by a single configuration bit. The merged result is gated by an arm input and registered, so the trigger output is a clean one-cycle-latency pulse. The capture logic that sits downstream uses this pulse to start or mark its sample window. When no term is enabled, the trigger never fires.

Top module: `trig_eval`

## Requirements
- R1: A bus term is true only when every bit of probe bus i, at bits [i*BUS_W +: BUS_W] of `bus_probe`, equals the same field of `bus_val`. A difference in any single bit makes the term false.
- R2: Flag condition code 2'b00 makes the term true while the flag is low, and code 2'b01 makes it true while the flag is high. Flag i's code sits at bits [2*i +: 2] of `flag_cond`.
- R3: Code 2'b10 (rising) makes the term true when the flag is 1 now and was 0 at the previous clock edge. Code 2'b11 (falling) makes it true when the flag is 0 now and was 1 at the previous clock edge. The previous-value register resets to 0.
- R4: After a single transition, an edge term is true for exactly one cycle, so `trig` pulses for a single cycle while the flag then holds steady.
- R5: A term whose enable bit (`bus_en[i]` or `flag_en[i]`) is 0 has no effect on `trig`, whatever its probe value.
- R6: With `use_or`=0 the condition is the AND of all enabled terms. With `use_or`=1 it is the OR of all enabled terms.
- R7: With no term enabled, `trig` stays 0 in both AND and OR mode.
- R8: When `arm` was 0 at a clock edge, `trig` is 0 after that edge.
- R9: `trig` is registered: after each rising edge it shows the condition evaluated on the inputs just before that edge. It is 0 after a cycle with `rst_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Enables the trigger output when high |
| use_or | input | 1 | 0 = AND of enabled terms, 1 = OR |
| bus_probe | input | NUM_BUS*BUS_W | Packed multi-bit probe buses |
| bus_val | input | NUM_BUS*BUS_W | Packed match values, one field per bus |
| bus_en | input | NUM_BUS | Per-bus term enable |
| flag_probe | input | NUM_FLAG | Single-bit probes |
| flag_cond | input | 2*NUM_FLAG | Per-flag condition code, 2 bits each |
| flag_en | input | NUM_FLAG | Per-flag term enable |
| trig | output | 1 | Registered trigger pulse |

## Verification
Directed patterns come first. They test an empty condition in both modes, arm held low while every term matches, and bus values that differ from their match in only the top bit. Together these separate the empty-set rule, the gating and the width of the equality test. Each flag is then driven through all four transitions under each of the four condition codes. This tells level codes apart from edge codes and shows that an edge term lasts one cycle. A long pseudo-random sweep over every input bit of a small configuration, checked against an arithmetic model of AND/OR over enabled terms, separates the two operators. It also shows that disabled terms are ignored.

// File: rtl/trig_pkg.sv
// Package: shared types for the trigger evaluator.
// Assumes: 2-bit flag condition codes as listed in the brief.
package trig_pkg;
    typedef enum logic [1:0] {
        COND_LOW  = 2'b00,
        COND_HIGH = 2'b01,
        COND_RISE = 2'b10,
        COND_FALL = 2'b11
    } flag_cond_e;
endpackage

// File: rtl/trig_bus_match.sv
// Module: exact equality term for one multi-bit probe bus.
// Assumes: match value has the same width as the probe.
module trig_bus_match #(
    parameter int BUS_W = 3
) (
    input  logic [BUS_W-1:0] probe,
    input  logic [BUS_W-1:0] value,
    output logic             hit
);
    // Compare all bits for an exact match.
    always_comb hit = (probe == value);
endmodule

// File: rtl/trig_flag_match.sv
// Module: level/edge term for one single-bit probe.
// Assumes: probe is synchronous to clk; previous value resets to 0.
module trig_flag_match
    import trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       probe,
    input  logic [1:0] cond,
    output logic       hit
);
    logic       prev_q;
    flag_cond_e cond_e;

    // Hold the probe value seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= probe;
    end

    // Select the condition the term tests.
    always_comb begin
        cond_e = flag_cond_e'(cond);
        unique case (cond_e)
            COND_LOW:  hit = ~probe;
            COND_HIGH: hit = probe;
            COND_RISE: hit = probe & ~prev_q;
            COND_FALL: hit = ~probe & prev_q;
            default:   hit = 1'b0;
        endcase
    end

    // R4: an edge hit cannot repeat in the following cycle under the same code.
    a_r4_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hit) && $past(cond[1]) && ($past(cond) == cond)) |-> !hit);
endmodule

// File: rtl/trig_combine.sv
// Module: merges enabled terms with one operator and registers the result.
// Assumes: an empty term set never fires.
module trig_combine #(
    parameter int N_TERMS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic               use_or,
    input  logic [N_TERMS-1:0] term_hit,
    input  logic [N_TERMS-1:0] term_en,
    output logic               trig
);
    logic any_en;
    logic all_ok;
    logic some_ok;
    logic cond_now;

    // Reduce the enabled terms under both operators.
    always_comb begin
        any_en   = |term_en;
        all_ok   = &(term_hit | ~term_en);
        some_ok  = |(term_hit & term_en);
        cond_now = any_en & (use_or ? some_ok : all_ok);
    end

    // Register the gated trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) trig <= 1'b0;
        else        trig <= arm & cond_now;
    end

    // R8: disarmed edge gives no trigger.
    a_r8_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(arm) |-> !trig);
    // R7: no enabled term gives no trigger.
    a_r7_empty: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(term_en) == '0) |-> !trig);
endmodule

// File: rtl/trig_eval.sv
// Module: top of the trigger evaluator; one term per bus and per flag.
// Assumes: all probes and configuration are synchronous to clk.
module trig_eval #(
    parameter int NUM_BUS  = 2,
    parameter int BUS_W    = 3,
    parameter int NUM_FLAG = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      arm,
    input  logic                      use_or,
    input  logic [NUM_BUS*BUS_W-1:0]  bus_probe,
    input  logic [NUM_BUS*BUS_W-1:0]  bus_val,
    input  logic [NUM_BUS-1:0]        bus_en,
    input  logic [NUM_FLAG-1:0]       flag_probe,
    input  logic [2*NUM_FLAG-1:0]     flag_cond,
    input  logic [NUM_FLAG-1:0]       flag_en,
    output logic                      trig
);
    localparam int N_TERMS = NUM_BUS + NUM_FLAG;

    logic [NUM_BUS-1:0]  bus_hit;
    logic [NUM_FLAG-1:0] flag_hit;

    // One equality term per probe bus.
    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        trig_bus_match #(.BUS_W(BUS_W)) u_bus (
            .probe (bus_probe[b*BUS_W +: BUS_W]),
            .value (bus_val[b*BUS_W +: BUS_W]),
            .hit   (bus_hit[b])
        );
    end

    // One level/edge term per flag.
    for (genvar f = 0; f < NUM_FLAG; f++) begin : g_flag
        trig_flag_match u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .probe (flag_probe[f]),
            .cond  (flag_cond[2*f +: 2]),
            .hit   (flag_hit[f])
        );
    end

    trig_combine #(.N_TERMS(N_TERMS)) u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .use_or   (use_or),
        .term_hit ({flag_hit, bus_hit}),
        .term_en  ({flag_en, bus_en}),
        .trig     (trig)
    );

    // R6: in AND mode a trigger means every enabled bus term matched.
    a_r6_and_all: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !$past(use_or)) |-> (&($past(bus_hit) | ~$past(bus_en))));
    // R1: AND-mode trigger with bus 0 enabled implies exact bus 0 match.
    a_r1_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !$past(use_or) && $past(bus_en[0])) |->
        ($past(bus_probe[BUS_W-1:0]) == $past(bus_val[BUS_W-1:0])));
endmodule

// File: tb/trig_eval_test.sv
module trig_eval_test;
    localparam int NB = 2;
    localparam int BW = 3;
    localparam int NF = 2;

    logic clk = 1'b0;
    logic rst_n, arm, use_or;
    logic [NB*BW-1:0] bus_probe, bus_val;
    logic [NB-1:0] bus_en;
    logic [NF-1:0] flag_probe, flag_en, fprev;
    logic [2*NF-1:0] flag_cond;
    logic trig;
    int checks = 0;
    int errors = 0;
    logic exp_v;

    trig_eval #(.NUM_BUS(NB), .BUS_W(BW), .NUM_FLAG(NF)) uut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .use_or(use_or),
        .bus_probe(bus_probe), .bus_val(bus_val), .bus_en(bus_en),
        .flag_probe(flag_probe), .flag_cond(flag_cond), .flag_en(flag_en),
        .trig(trig));

    always #5 clk = ~clk;

    // Model built from R1, R2, R3, R5, R6, R7.
    function automatic logic model();
        logic any_e = 1'b0, all_h = 1'b1, some_h = 1'b0, h;
        for (int b = 0; b < NB; b++) begin
            h = (bus_probe[b*BW +: BW] == bus_val[b*BW +: BW]);
            if (bus_en[b]) begin any_e = 1'b1; all_h &= h; some_h |= h; end
        end
        for (int f = 0; f < NF; f++) begin
            case (flag_cond[2*f +: 2])
                2'b00: h = !flag_probe[f];
                2'b01: h = flag_probe[f];
                2'b10: h = flag_probe[f] && !fprev[f];
                default: h = !flag_probe[f] && fprev[f];
            endcase
            if (flag_en[f]) begin any_e = 1'b1; all_h &= h; some_h |= h; end
        end
        return arm && any_e && (use_or ? some_h : all_h);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: trig actual %b expected %b", req, act, exp);
        end
    endtask

    // Advance one cycle and compare trig with the model (R9 latency).
    task automatic cyc(input string req);
        exp_v = model();
        @(posedge clk);
        fprev = flag_probe;
        @(negedge clk);
        check(req, trig, exp_v);
    endtask

    task automatic edge_case(input logic [1:0] cond, input logic a, input logic b);
        bus_en = '0; flag_en = 2'b01; use_or = 1'b0; arm = 1'b1;
        flag_cond = {2'b00, cond};
        flag_probe[0] = a; cyc("R2");
        flag_probe[0] = b; cyc("R3");
        cyc("R4");
    endtask

    initial begin
        rst_n = 1'b0; arm = 1'b0; use_or = 1'b0;
        bus_probe = '0; bus_val = '0; bus_en = '0;
        flag_probe = '0; flag_cond = '0; flag_en = '0; fprev = '0;
        repeat (3) @(negedge clk);
        check("R9", trig, 1'b0);
        rst_n = 1'b1;

        // R7: empty condition in both modes, everything else matching.
        arm = 1'b1; bus_probe = 6'o52; bus_val = 6'o52; flag_probe = 2'b11;
        flag_cond = 4'b0101;
        use_or = 1'b0; cyc("R7"); check("R7", trig, 1'b0);
        use_or = 1'b1; cyc("R7"); check("R7", trig, 1'b0);

        // R8: disarmed while all terms match.
        bus_en = 2'b11; flag_en = 2'b11; arm = 1'b0;
        cyc("R8"); check("R8", trig, 1'b0);
        arm = 1'b1; cyc("R6"); check("R6", trig, 1'b1);

        // R1: top bit of bus 1 differs only.
        use_or = 1'b0; bus_en = 2'b10; flag_en = '0;
        bus_probe = 6'o32; bus_val = 6'o72; cyc("R1"); check("R1", trig, 1'b0);
        bus_probe = 6'o72; cyc("R1"); check("R1", trig, 1'b1);

        // R2-R4: all codes against all transitions on flag 0.
        for (int c = 0; c < 4; c++)
            for (int t = 0; t < 4; t++)
                edge_case(c[1:0], t[1], t[0]);

        // R5/R6: pseudo-random sweep across every input bit.
        for (int i = 0; i < 6000; i++) begin
            arm = ($urandom % 8) != 0;
            use_or = $urandom;
            bus_en = $urandom; flag_en = $urandom;
            bus_val = $urandom;
            bus_probe = ($urandom % 2) ? bus_val : 6'($urandom);
            flag_probe = $urandom; flag_cond = $urandom;
            cyc(use_or ? "R6_or_R5" : "R6_and_R5");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule